// File: doc/BRIEF.md
# Fault Status Latch and Interrupter

This block gathers per-channel health bits for a multi-channel measurement front end and presents them to a host. A background scanner supplies three live bit vectors on every scan tick: signal present, reference present and accuracy good. Each vector is filtered so that a loss counts only once it has lasted several ticks. The filtered result is masked by an active-channel register and then fed to its own status register. A 1 in a status register means healthy and a 0 means failed.

When a bit in a status register drops, the register freezes and a failure interrupt request is raised. While the register is frozen, later scans keep updating a background shadow copy. A host read of a frozen register returns the frozen value and releases it. In the same cycle the shadow copy is loaded into the register, so the host can read the new value on its next access. The interrupt uses a programmable priority level. An acknowledge clears the request and returns the failure vector on the read data bus. Any fault that arrives after an acknowledge raises the request again.

Top module: `fault_status_irq`

## Requirements
- R1: Three status registers hold one bit per channel, with 1 meaning healthy. They sit at address 0 (signal), address 1 (reference) and address 2 (accuracy). After reset they read all ones. Writes to these addresses have no effect.
- R2: A channel's live bit must be low on LOSS_TICKS consecutive scan ticks (default 3) before a loss is declared. The loss is declared on the last of those ticks. A single high tick declares the channel healthy again at that tick and restarts the count.
- R3: The active-channel register sits at address 3 and reads 0 after reset. When a channel's bit in it is 0, that channel reports 1 at every update of all three status registers, and its faults raise no interrupt.
- R4: A bit that drops from 1 to 0 at an update latches the register. While latched, the visible value does not change on scan ticks.
- R5: While a register is latched, every scan tick stores the filtered status in a shadow copy. A read of a latched register returns the frozen value and loads the shadow copy into the register in the same cycle. If that load drops any bit from 1 to 0, the register latches again and raises a new fault.
- R6: An unlatched register takes the filtered, masked status on every scan tick. Reading an unlatched register changes nothing.
- R7: A fault sets the pending request when the level register (address 4) is not 0. irq_o follows the pending request while the level is not 0, and irq_level_o gives the level. The level register keeps only write-data bits 2:0; bits 15:3 are ignored and read as 0.
- R8: iack_i clears the pending request. One cycle later, bus_rdata_o carries the failure vector (address 5, 8 bits, zero-extended). A fault in the same cycle as iack_i leaves the request asserted.
- R9: The alert vector sits at address 6 as a separate 8-bit register. Its value is never returned on an acknowledge.
- R10: Read data is registered and is valid in the cycle after the request. Addresses 7 to 15 read as 0. A bus access in a cycle where iack_i is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_tick_i | input | 1 | One-cycle strobe marking a scan result |
| sig_ok_i | input | NCH | Live signal-present bits |
| ref_ok_i | input | NCH | Live reference-present bits |
| acc_ok_i | input | NCH | Live accuracy-good bits |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read or acknowledge data |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| irq_o | output | 1 | Failure interrupt request |
| irq_level_o | output | 3 | Programmed interrupt priority |

## Verification
Two events can land in the same cycle: the final tick of a loss filter, which produces a fresh fault, and the host's interrupt acknowledge. The bench makes them coincide by starting a second channel's loss one tick after the first. The first loss raises the request, and the acknowledge is strobed together with the scan tick that completes the second loss. The request must still be high afterwards, and the acknowledge data must carry the failure vector. A register write issued in that same cycle must leave no trace.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  localparam int NUM_STAT = 3;
  localparam int LVL_W    = 3;
  localparam int VEC_W    = 8;
  localparam int ADDR_W   = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADR_SIG  = 4'd0,
    ADR_REF  = 4'd1,
    ADR_ACC  = 4'd2,
    ADR_ACT  = 4'd3,
    ADR_LVL  = 4'd4,
    ADR_FVEC = 4'd5,
    ADR_AVEC = 4'd6
  } reg_addr_e;
endpackage

// File: rtl/fsl_loss_filter.sv
module fsl_loss_filter #(
  parameter int NCH        = 16,
  parameter int LOSS_TICKS = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [NCH-1:0] ok_i,
  output logic [NCH-1:0] ok_o   // status as judged if a tick lands now
);
  localparam int CW = $clog2(LOSS_TICKS + 1);
  localparam logic [CW-1:0] LIM    = CW'(LOSS_TICKS);
  localparam logic [CW-1:0] LIM_M1 = CW'(LOSS_TICKS - 1);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (tick_i) begin
        if (ok_i[i])        cnt_q <= '0;
        else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      end
    end

    assign ok_o[i] = ok_i[i] | (cnt_q < LIM_M1);
  end
endmodule

// File: rtl/fsl_status_latch.sv
module fsl_status_latch #(
  parameter int NCH = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [NCH-1:0] eff_i,
  input  logic           rel_i,
  output logic [NCH-1:0] vis_o,
  output logic           lat_o,
  output logic           fault_o
);
  logic [NCH-1:0] vis_q, shd_q, src;
  logic           lat_q, rel_commit, commit;

  assign rel_commit = rel_i & lat_q;
  assign commit     = rel_commit | (tick_i & ~lat_q);
  assign src        = rel_commit ? shd_q : eff_i;
  assign fault_o    = commit & (|(vis_q & ~src));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q <= '1;
      shd_q <= '1;
      lat_q <= 1'b0;
    end else begin
      if (tick_i) shd_q <= eff_i;
      if (commit) begin
        vis_q <= src;
        lat_q <= fault_o;
      end
    end
  end

  assign vis_o = vis_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/fsl_irq_ctrl.sv
module fsl_irq_ctrl
  import fsl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic             iack_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             irq_o
);
  logic pend_q, lvl_on;

  assign lvl_on = (level_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= 1'b0;
    else if (fault_i && lvl_on) pend_q <= 1'b1;   // new fault wins over ack
    else if (iack_i)            pend_q <= 1'b0;
  end

  assign irq_o = pend_q & lvl_on;
endmodule

// File: rtl/fault_status_irq.sv
module fault_status_irq
  import fsl_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int DW         = 16,
  parameter int LOSS_TICKS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_tick_i,
  input  logic [NCH-1:0]    sig_ok_i,
  input  logic [NCH-1:0]    ref_ok_i,
  input  logic [NCH-1:0]    acc_ok_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              iack_i,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_level_o
);
  logic [NUM_STAT-1:0][NCH-1:0] live, filt_ok, vis;
  logic [NUM_STAT-1:0]          rel_vec, lat_vec, fault_vec;
  logic [NCH-1:0]               active_q;
  logic [LVL_W-1:0]             level_q;
  logic [VEC_W-1:0]             fvec_q, avec_q;
  logic [DW-1:0]                rdata_q, rd_mux;
  logic                         bus_acc, fault_any;

  assign live      = {acc_ok_i, ref_ok_i, sig_ok_i};
  assign bus_acc   = bus_req_i & ~iack_i;
  assign fault_any = |fault_vec;

  for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
    assign rel_vec[k] = bus_acc & ~bus_we_i & (bus_addr_i == ADDR_W'(k));

    fsl_loss_filter #(.NCH(NCH), .LOSS_TICKS(LOSS_TICKS)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (scan_tick_i),
      .ok_i   (live[k]),
      .ok_o   (filt_ok[k])
    );

    fsl_status_latch #(.NCH(NCH)) u_lat (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (scan_tick_i),
      .eff_i   (filt_ok[k] | ~active_q),
      .rel_i   (rel_vec[k]),
      .vis_o   (vis[k]),
      .lat_o   (lat_vec[k]),
      .fault_o (fault_vec[k])
    );
  end

  fsl_irq_ctrl u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (fault_any),
    .iack_i  (iack_i),
    .level_i (level_q),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      level_q  <= '0;
      fvec_q   <= '0;
      avec_q   <= '0;
    end else if (bus_acc && bus_we_i) begin
      case (bus_addr_i)
        ADR_ACT:  active_q <= bus_wdata_i[NCH-1:0];
        ADR_LVL:  level_q  <= bus_wdata_i[LVL_W-1:0];
        ADR_FVEC: fvec_q   <= bus_wdata_i[VEC_W-1:0];
        ADR_AVEC: avec_q   <= bus_wdata_i[VEC_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr_i)
      ADR_SIG:  rd_mux = DW'(vis[0]);
      ADR_REF:  rd_mux = DW'(vis[1]);
      ADR_ACC:  rd_mux = DW'(vis[2]);
      ADR_ACT:  rd_mux = DW'(active_q);
      ADR_LVL:  rd_mux = DW'(level_q);
      ADR_FVEC: rd_mux = DW'(fvec_q);
      ADR_AVEC: rd_mux = DW'(avec_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rdata_q <= '0;
    else if (iack_i)                  rdata_q <= DW'(fvec_q);
    else if (bus_acc && !bus_we_i)    rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_level_o = level_q;
endmodule

// File: rtl/fault_status_irq_chk.sv
module fault_status_irq_chk #(
  parameter int NCH = 16,
  parameter int DW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           iack_i,
  input logic           irq_o,
  input logic [DW-1:0]  bus_rdata_o,
  input logic [2:0]     lat_vec,
  input logic [2:0]     rel_vec,
  input logic [2:0]     fault_vec,
  input logic [NCH-1:0] vis_sig,
  input logic [2:0]     level_q,
  input logic [7:0]     fvec_q
);
  AST_LATCH_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_vec[0] |=> lat_vec[0]);                                     // R4
  AST_HOLD_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_vec[0] && !rel_vec[0] |=> $stable(vis_sig));                  // R4
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_i && !(|fault_vec) |=> !irq_o);                              // R8
  AST_FAULT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fault_vec) && level_q != 3'd0 |=> irq_o || level_q == 3'd0);    // R7
  AST_ACK_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_i |=> bus_rdata_o == DW'($past(fvec_q)));                    // R8
endmodule

bind fault_status_irq fault_status_irq_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iack_i      (iack_i),
  .irq_o       (irq_o),
  .bus_rdata_o (bus_rdata_o),
  .lat_vec     (lat_vec),
  .rel_vec     (rel_vec),
  .fault_vec   (fault_vec),
  .vis_sig     (vis[0]),
  .level_q     (level_q),
  .fvec_q      (fvec_q)
);

// File: tb/fault_status_irq_test.sv
module fault_status_irq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scan_tick_i = 1'b0;
  logic [15:0] sig_ok_i = '1, ref_ok_i = '1, acc_ok_i = '1;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        iack_i = 1'b0;
  logic        irq_o;
  logic [2:0]  irq_level_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] rd;

  always #5 clk_i = ~clk_i;

  fault_status_irq uut (.*);

  // {addr, write data, expected readback}
  localparam logic [35:0] CFG_TBL [0:6] = '{
    {4'd0, 16'h0000, 16'hFFFF},   // R1 write ignored
    {4'd1, 16'h0000, 16'hFFFF},   // R1
    {4'd3, 16'hFFFF, 16'hFFFF},   // R3
    {4'd4, 16'h00FF, 16'h0007},   // R7 upper bits dropped
    {4'd5, 16'h125A, 16'h005A},   // R8
    {4'd6, 16'h77C3, 16'h00C3},   // R9
    {4'd7, 16'hBEEF, 16'h0000}    // R10
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) scan_tick_i = 1'b1;
      @(negedge clk_i) scan_tick_i = 1'b0;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    @(negedge clk_i);
    bus_req_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic ack(output logic [15:0] d);
    @(negedge clk_i) iack_i = 1'b1;
    @(negedge clk_i) iack_i = 1'b0;
    d = bus_rdata_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state
    rdreg(4'd0, rd); check("R1 sig reset", rd, 16'hFFFF);
    rdreg(4'd2, rd); check("R1 acc reset", rd, 16'hFFFF);
    rdreg(4'd3, rd); check("R3 active reset", rd, 16'h0000);
    check("R7 irq reset", {15'd0, irq_o}, 16'd0);

    for (int i = 0; i < 7; i++) begin
      wr(CFG_TBL[i][35:32], CFG_TBL[i][31:16]);
      rdreg(CFG_TBL[i][35:32], rd);
      check("R10 table", rd, CFG_TBL[i][15:0]);
    end
    check("R7 level out", {13'd0, irq_level_o}, 16'd7);

    // R2 loss needs three ticks
    sig_ok_i = 16'hFFFE;
    tick(2);
    rdreg(4'd0, rd); check("R2 before limit", rd, 16'hFFFF);
    check("R2 no irq yet", {15'd0, irq_o}, 16'd0);
    tick(1);
    check("R7 irq on fault", {15'd0, irq_o}, 16'd1);
    rdreg(4'd0, rd); check("R4 latched value", rd, 16'hFFFE);
    ack(rd);
    check("R8 ack vector", rd, 16'h005A);
    check("R9 not alert vector", {15'd0, rd == 16'h00C3}, 16'd0);
    check("R8 irq cleared", {15'd0, irq_o}, 16'd0);

    // R4/R5 shadow while latched
    sig_ok_i = 16'hFFFC;
    tick(3);
    check("R8 refire after ack", {15'd0, irq_o}, 16'd1);
    ack(rd);
    sig_ok_i = 16'hFFFB;
    tick(3);
    check("R4 no irq while frozen", {15'd0, irq_o}, 16'd0);
    rdreg(4'd0, rd); check("R4 frozen read", rd, 16'hFFFC);
    check("R5 relatch irq", {15'd0, irq_o}, 16'd1);
    rdreg(4'd0, rd); check("R5 shadow loaded", rd, 16'hFFFB);
    ack(rd);

    // R6 follow and immediate restore
    sig_ok_i = 16'hFFFF;
    tick(1);
    rdreg(4'd0, rd); check("R6 follows", rd, 16'hFFFF);

    // R2 interrupted loss
    ref_ok_i = 16'hFFFE; tick(2);
    ref_ok_i = 16'hFFFF; tick(1);
    ref_ok_i = 16'hFFFE; tick(2);
    rdreg(4'd1, rd); check("R2 count restarted", rd, 16'hFFFF);
    check("R2 no irq", {15'd0, irq_o}, 16'd0);

    // R3 masking
    wr(4'd3, 16'hFFFE);
    tick(1);
    rdreg(4'd1, rd); check("R3 masked channel", rd, 16'hFFFF);
    check("R3 no irq", {15'd0, irq_o}, 16'd0);
    acc_ok_i = 16'h0000; tick(3);
    rdreg(4'd2, rd); check("R3 acc masked bit", rd, 16'h0001);
    ack(rd);
    acc_ok_i = 16'hFFFF; tick(1);
    rdreg(4'd2, rd); check("R6 acc restored", rd, 16'hFFFF);

    // R8 ack and fault in the same cycle
    sig_ok_i = 16'hFFEF; tick(1);
    acc_ok_i = 16'hFFFD; tick(2);
    check("R7 sig fault irq", {15'd0, irq_o}, 16'd1);
    @(negedge clk_i);
    scan_tick_i = 1'b1; iack_i = 1'b1;
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 4'd3; bus_wdata_i = 16'h0000;
    @(negedge clk_i);
    scan_tick_i = 1'b0; iack_i = 1'b0; bus_req_i = 1'b0; bus_we_i = 1'b0;
    check("R8 same-cycle ack data", bus_rdata_o, 16'h005A);
    check("R8 same-cycle irq kept", {15'd0, irq_o}, 16'd1);
    rdreg(4'd3, rd); check("R10 write during ack ignored", rd, 16'hFFFE);
    ack(rd);
    check("R8 cleared", {15'd0, irq_o}, 16'd0);

    // R7 level zero disables
    wr(4'd4, 16'h0000);
    ref_ok_i = 16'hFFEE; tick(3);
    check("R7 disabled level", {15'd0, irq_o}, 16'd0);
    rdreg(4'd1, rd); check("R7 status still latched", rd, 16'hFFEF);

    finish_run();
  end
endmodule